// File: doc/BRIEF.md
# Cascadable Presettable Four-Bit Counter

This block is a four-bit up-counter that changes state on the rising clock edge. A build parameter chooses the count sequence. In decade mode it counts 0 through 9 in 8421 code. In binary mode it counts 0 through 15. A second build parameter chooses how the active-low clear acts. In asynchronous mode it forces the count to zero at once. In synchronous mode it forces the count to zero at the next rising edge.

The block has two active-high count enables. The parallel enable only gates counting. The trickle enable gates counting and also the terminal-count output. Because of this, several stages can be chained without ripple delay: each stage's terminal count drives the trickle enable of the next stage, and all stages share one clock. An active-low load input copies a four-bit word into the counter on the next rising edge.

Top module: `casc_count4`

## Requirements
- R1: With DECADE=1, each enabled count adds one for values 0 to 8, and value 9 (1001) steps to 0 (0000).
- R2: With DECADE=0, each enabled count adds one for values 0 to 14, and value 15 (1111) steps to 0 (0000).
- R3: With ASYNC_CLR=1, a low level on clr_n drives count to 0 with no clock edge. This overrides every other input.
- R4: With ASYNC_CLR=0, if clr_n is low at a rising edge, count becomes 0 at that edge, even when load_n is low or both enables are high.
- R5: If clr_n is high and load_n is low at a rising edge, count takes the value of data_in at that edge, whatever the levels of en_par and en_trk.
- R6: If clr_n and load_n are both high, the counter advances only when en_par and en_trk are both high. If either enable is low, count keeps its value.
- R7: carry_out is high exactly when en_trk is high and count holds the final value (9 in decade mode, 15 in binary mode). It follows en_trk with no clock edge. A chain that feeds one stage's carry_out into the next stage's en_trk steps the upper stage once for each wrap of the lower stage.
- R8: With DECADE=1, a loaded value from 10 to 15 goes to 0 on the next enabled count.
- R9: Apart from the asynchronous clear, count changes only at a rising clock edge. Changing the inputs between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. State changes on the rising edge. |
| clr_n | input | 1 | Active-low clear. Asynchronous or synchronous, as set by ASYNC_CLR. |
| load_n | input | 1 | Active-low parallel load enable. |
| data_in | input | 4 | Value to load. |
| en_par | input | 1 | Count enable that gates counting only. |
| en_trk | input | 1 | Count enable that gates counting and carry_out. |
| count | output | 4 | Present count. |
| carry_out | output | 1 | Terminal count, for cascading stages. |

## Verification
Results that depend on the clock (load, count, hold and synchronous clear) are due one rising edge after the inputs that cause them. The bench drives inputs on the falling edge and compares at the next falling edge, half a period after the active edge. The asynchronous clear and the trickle-enable path to carry_out need no edge. The bench checks them 1 ns after changing the input, well before the next rising edge, and in the same gap it confirms that a change to load or data has not moved the count. The two-stage decade chain is compared every cycle against a running modulo-100 total, and the bench also counts how many times the upper stage steps.

// File: rtl/casc_count4_pkg.sv
package casc_count4_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t DEC_LAST = cnt_t'(9);
    localparam cnt_t BIN_LAST = '1;

    // Modes in order of precedence.
    typedef enum logic [1:0] {
        MODE_CLR   = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } mode_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_par;
        logic en_trk;
    } ctl_t;

    function automatic cnt_t last_of(input bit dec);
        return dec ? DEC_LAST : BIN_LAST;
    endfunction

    // One enabled step. In decade mode any value at or above 9 wraps to 0.
    function automatic cnt_t cnt_step(input cnt_t q, input bit dec);
        if (dec && (q >= DEC_LAST))
            return '0;
        return q + cnt_t'(1);
    endfunction

    function automatic mode_e pick_mode(input ctl_t c);
        if (!c.clr_n)
            return MODE_CLR;
        if (!c.load_n)
            return MODE_LOAD;
        if (c.en_par && c.en_trk)
            return MODE_COUNT;
        return MODE_HOLD;
    endfunction

endpackage

// File: rtl/casc_count4_mode.sv
module casc_count4_mode
    import casc_count4_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  ctl_t ctl,
    input  cnt_t data_in,
    input  cnt_t q,
    output cnt_t d
);

    mode_e mode;

    always_comb begin
        mode = pick_mode(ctl);
        unique case (mode)
            MODE_CLR:   d = '0;
            MODE_LOAD:  d = data_in;
            MODE_COUNT: d = cnt_step(q, DECADE);
            default:    d = q;
        endcase
    end

endmodule

// File: rtl/casc_count4_reg.sv
module casc_count4_reg
    import casc_count4_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic clk,
    input  logic clr_n,
    input  cnt_t d,
    output cnt_t q
);

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q <= '0;
                else
                    q <= d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= clr_n ? d : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/casc_count4_term.sv
module casc_count4_term
    import casc_count4_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  cnt_t q,
    input  logic en_trk,
    output logic tc
);

    localparam cnt_t LAST = last_of(DECADE);

    always_comb tc = en_trk && (q == LAST);

endmodule

// File: rtl/casc_count4.sv
module casc_count4
    import casc_count4_pkg::*;
#(
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b1
) (
    input  logic       clk,
    input  logic       clr_n,
    input  logic       load_n,
    input  logic [3:0] data_in,
    input  logic       en_par,
    input  logic       en_trk,
    output logic [3:0] count,
    output logic       carry_out
);

    ctl_t ctl;
    cnt_t d_next;
    cnt_t q_cur;

    always_comb begin
        ctl.clr_n  = clr_n;
        ctl.load_n = load_n;
        ctl.en_par = en_par;
        ctl.en_trk = en_trk;
    end

    casc_count4_mode #(.DECADE(DECADE)) u_mode (
        .ctl     (ctl),
        .data_in (data_in),
        .q       (q_cur),
        .d       (d_next)
    );

    casc_count4_reg #(.ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (d_next),
        .q     (q_cur)
    );

    casc_count4_term #(.DECADE(DECADE)) u_term (
        .q      (q_cur),
        .en_trk (en_trk),
        .tc     (carry_out)
    );

    assign count = q_cur;

endmodule

// File: rtl/casc_count4_chk.sv
module casc_count4_chk
    import casc_count4_pkg::*;
#(
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b1
) (
    input logic       clk,
    input logic       clr_n,
    input logic       load_n,
    input logic [3:0] data_in,
    input logic       en_par,
    input logic       en_trk,
    input logic [3:0] count,
    input logic       carry_out
);

    localparam cnt_t LAST = last_of(DECADE);

    logic started;
    initial started = 1'b0;
    always @(posedge clk) started <= 1'b1;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> (count == cnt_step($past(count), DECADE)));

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n) |=> (count == $past(data_in)));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));

    // R7
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (en_trk && (count == LAST)));

    // R7
    carry_fire_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (en_trk && (count == LAST)) |-> carry_out);

    generate
        if (DECADE) begin : g_dec
            // R8
            dec_range_chk: assert property (@(posedge clk) disable iff (!clr_n)
                (load_n && en_par && en_trk && (count > 4'd9)) |=> (count == 4'd0));
        end
        if (ASYNC_CLR) begin : g_aclr
            // R3
            async_zero_chk: assert property (@(posedge clk) disable iff (!started)
                (!clr_n) |-> (count == 4'd0));
        end else begin : g_sclr
            // R4
            sync_zero_chk: assert property (@(posedge clk) disable iff (!started)
                (!clr_n) |=> (count == 4'd0));
        end
    endgenerate

endmodule

bind casc_count4 casc_count4_chk #(.DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .data_in   (data_in),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/sim_casc_count4.sv
`timescale 1ns/1ps
module sim_casc_count4;

    logic       clk = 1'b0;
    logic       clr_n, load_n, en_par, en_trk;
    logic [3:0] data_in;
    logic [3:0] q0, q1;
    logic       tc0, tc1;

    logic       c_clr_n, c_en;
    logic [3:0] lo_q, hi_q;
    logic       lo_tc, hi_tc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [3:0] m0, m1;

    always #2 clk = ~clk;

    // Decade sequence, asynchronous clear
    casc_count4 #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
        .en_par(en_par), .en_trk(en_trk), .count(q0), .carry_out(tc0));

    // Binary sequence, synchronous clear
    casc_count4 #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) u1 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
        .en_par(en_par), .en_trk(en_trk), .count(q1), .carry_out(tc1));

    // Two-stage decade chain
    casc_count4 #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_lo (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .data_in(4'd0),
        .en_par(1'b1), .en_trk(c_en), .count(lo_q), .carry_out(lo_tc));
    casc_count4 #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) u_hi (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .data_in(4'd0),
        .en_par(1'b1), .en_trk(lo_tc), .count(hi_q), .carry_out(hi_tc));

    function automatic logic [3:0] ref_next(bit dec, logic [3:0] q, logic c,
                                            logic l, logic [3:0] d, logic p, logic t);
        if (!c) return 4'd0;
        if (!l) return d;
        if (p && t) begin
            if (dec) return (q >= 4'd9) ? 4'd0 : q + 4'd1;
            return q + 4'd1;
        end
        return q;
    endfunction

    function automatic logic ref_tc(bit dec, logic [3:0] q, logic t);
        return t && (q == (dec ? 4'd9 : 4'd15));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(logic c, logic l, logic [3:0] d, logic p, logic t);
        clr_n = c; load_n = l; data_in = d; en_par = p; en_trk = t;
    endtask

    // One rising edge; inputs are already set; compare at the falling edge.
    task automatic tick(string tag0, string tag1);
        logic [3:0] e0, e1;
        e0 = ref_next(1'b1, m0, clr_n, load_n, data_in, en_par, en_trk);
        e1 = ref_next(1'b0, m1, clr_n, load_n, data_in, en_par, en_trk);
        @(negedge clk);
        m0 = e0; m1 = e1;
        chk(tag0, q0, m0);
        chk(tag1, q1, m1);
        chk("R7 carry decade", tc0, ref_tc(1'b1, m0, en_trk));
        chk("R7 carry binary", tc1, ref_tc(1'b0, m1, en_trk));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        drive(1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
        c_clr_n = 1'b0; c_en = 1'b0;
        m0 = 4'd0; m1 = 4'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 reset decade", q0, 0);
        chk("R4 reset binary", q1, 0);

        // R5: load while both enables are low
        drive(1'b1, 1'b0, 4'd7, 1'b0, 1'b0);
        tick("R5 load decade", "R5 load binary");

        // R3: asynchronous clear between edges; R4: synchronous one waits
        drive(1'b0, 1'b1, 4'd7, 1'b1, 1'b1);
        #1;
        chk("R3 async clear now", q0, 0);
        chk("R4 sync clear waits", q1, 7);
        m0 = 4'd0;
        @(negedge clk);
        m1 = 4'd0;
        chk("R4 sync clear at edge", q1, 0);

        // R4: clear beats load
        drive(1'b1, 1'b0, 4'd5, 1'b0, 1'b0);
        tick("R5 load", "R5 load");
        drive(1'b0, 1'b0, 4'd3, 1'b1, 1'b1);
        tick("R3 clear over load", "R4 clear over load");

        // R1: 9 -> 0; R2: 15 -> 0
        drive(1'b1, 1'b0, 4'd8, 1'b1, 1'b1);
        tick("R5 load 8", "R5 load 8");
        drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
        tick("R1 step to 9", "R2 step to 9");
        tick("R1 wrap 9", "R2 step 10");
        drive(1'b1, 1'b0, 4'd15, 1'b1, 1'b1);
        tick("R8 load 15", "R2 load 15");
        drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
        tick("R8 15 to 0", "R2 wrap 15");

        // R8: values 10..15 in decade mode return to 0
        for (int v = 10; v < 16; v++) begin
            drive(1'b1, 1'b0, 4'(v), 1'b0, 1'b1);
            tick("R8 load", "R2 load");
            drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
            tick("R8 illegal wraps", "R2 step");
        end

        // R6: either enable low holds
        drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1);
        tick("R6 hold par low", "R6 hold par low");
        drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b0);
        tick("R6 hold trk low", "R6 hold trk low");

        // R7: trickle enable reaches carry without an edge
        drive(1'b1, 1'b0, 4'd9, 1'b0, 1'b1);
        tick("R5 load 9", "R5 load 9");
        chk("R7 carry at 9", tc0, 1);
        en_trk = 1'b0;
        #1;
        chk("R7 carry drops with trk", tc0, 0);
        en_trk = 1'b1;
        #1;
        chk("R7 carry rises with trk", tc0, 1);

        // R9: changes between edges do not move the count
        drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        tick("R6 hold", "R6 hold");
        load_n = 1'b0; data_in = 4'd3; en_par = 1'b1; en_trk = 1'b1;
        #1;
        chk("R9 no move before edge dec", q0, m0);
        chk("R9 no move before edge bin", q1, m1);
        tick("R5 load 3", "R5 load 3");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            drive(($urandom % 12) != 0, ($urandom % 5) != 0, 4'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
            tick("R1 random decade", "R2 random binary");
        end

        // R7: two-stage chain counts 0..99
        begin
            int total = 0;
            int hi_steps = 0;
            logic [3:0] prev_hi;
            c_clr_n = 1'b0; c_en = 1'b0;
            @(negedge clk);
            c_clr_n = 1'b1; c_en = 1'b1;
            prev_hi = hi_q;
            for (int i = 0; i < 260; i++) begin
                c_en = ((i % 37) != 36);
                if (c_en) total = (total + 1) % 100;
                @(negedge clk);
                if (hi_q != prev_hi) hi_steps++;
                prev_hi = hi_q;
                chk("R7 chain value", hi_q * 10 + lo_q, total);
            end
            chk("R7 upper steps per lower wrap", hi_steps, 25);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule